// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block maps a 44-bit physical address onto one of up to sixteen targets. Software sets up each window through a small 32-bit register port. A window has three parts: an enable, a 4-bit target code and a pair of inclusive bounds. The bounds have 64 MB granularity, so only address bits 43:26 take part in the comparison.

Each valid request address is compared against every enabled window at once. One clock later the block reports a hit, the target of the winning window, or a miss. When more than one window covers the address, the window with the lowest index wins. A global bypass bit suppresses miss reporting, so an address that falls outside every window passes silently.

Register reads are combinational from the register address. Writes take effect at the clock edge that samples them.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset every register reads as zero: window control, both bounds and the global control. With no window enabled and bypass clear, a valid request yields a miss.
- R2: The window control word sits at window offset 0x0. Its enable is bit 0 and its target code is bits 11:8. All other bits read as zero, and the enable and target read back as written.
- R3: Window n occupies byte offsets n*0x10 onward. The low bound is at +0x8 and the high bound at +0xC, each holding address bits 43:26 in register bits 27:10 with the other bits reading zero. Offset +0x4 reads zero and ignores writes. The global control is at 0x100.
- R4: A request hits an enabled window when addr[43:26] >= low and addr[43:26] <= high. Both the lowest address of the low granule and the last address of the high granule hit.
- R5: A window whose enable is clear never hits. Clearing the enable leaves its target and bounds readable unchanged.
- R6: When several enabled windows cover the address, the target of the lowest-numbered window is reported.
- R7: Global control bit 1 is the miss bypass, and the other bits read zero. A valid request that hits no window raises the miss output only while bypass is clear. Hit and miss are never high together.
- R8: The decode result (valid, hit, miss, target) appears exactly one cycle after the request is sampled. All three flags are low one cycle after a cycle with no request.
- R9: A request sampled in the same cycle as a register write is decoded against the settings in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 9 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| req_valid | input | 1 | Request address valid |
| req_addr | input | 44 | Request physical address |
| dec_valid | output | 1 | Decode result valid |
| dec_hit | output | 1 | Address fell in an enabled window |
| dec_miss | output | 1 | Address fell in no window and bypass is clear |
| dec_target | output | 4 | Target code of the winning window |

## Verification
The interesting collision is a register write in the same cycle as a decode request. The bench drives a write that enables a window together with a request that only that window would cover, and expects a miss. It then drives a write that disables the window together with a matching request, and expects a hit. In both cases the follow-up request must show the new setting. A second collision occurs when the bypass bit changes in the same cycle as an unmatched request; the miss output must follow the bypass value held before that write.

// File: rtl/awd_pkg.sv
package awd_pkg;
    localparam int PA_W    = 44;
    localparam int GRAN_LSB = 26;
    localparam int BND_W   = PA_W - GRAN_LSB;
    localparam int BND_POS = 10;
    localparam int TGT_W   = 4;
    localparam int TGT_POS = 8;
    localparam int DATA_W  = 32;
    localparam int BYP_POS = 1;

    typedef struct packed {
        logic              en;
        logic [TGT_W-1:0]  tgt;
        logic [BND_W-1:0]  lo;
        logic [BND_W-1:0]  hi;
    } win_cfg_t;
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 16,
    localparam int IDX_W  = $clog2(NUM_WIN),
    localparam int SPAN_W = IDX_W + 4,
    localparam int RA_W   = SPAN_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  logic [RA_W-1:0]        addr_i,
    input  logic [DATA_W-1:0]      wdata_i,
    output logic [DATA_W-1:0]      rdata_o,
    output win_cfg_t [NUM_WIN-1:0] cfg_o,
    output logic                   bypass_o
);
    typedef struct packed {
        win_cfg_t [NUM_WIN-1:0] win;
        logic                   bypass;
    } rf_t;

    rf_t st_d, st_q;

    logic [IDX_W-1:0] idx;
    logic [1:0]       word;
    logic             in_win;
    logic             is_gctl;

    assign idx     = addr_i[SPAN_W-1:4];
    assign word    = addr_i[3:2];
    assign in_win  = !addr_i[RA_W-1];
    assign is_gctl = addr_i[RA_W-1] && (addr_i[SPAN_W-1:0] == '0);

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            if (is_gctl) begin
                st_d.bypass = wdata_i[BYP_POS];
            end else if (in_win) begin
                case (word)
                    2'd0: begin
                        st_d.win[idx].en  = wdata_i[0];
                        st_d.win[idx].tgt = wdata_i[TGT_POS +: TGT_W];
                    end
                    2'd2: st_d.win[idx].lo = wdata_i[BND_POS +: BND_W];
                    2'd3: st_d.win[idx].hi = wdata_i[BND_POS +: BND_W];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (is_gctl) begin
            rdata_o[BYP_POS] = st_q.bypass;
        end else if (in_win) begin
            case (word)
                2'd0: begin
                    rdata_o[0]                = st_q.win[idx].en;
                    rdata_o[TGT_POS +: TGT_W] = st_q.win[idx].tgt;
                end
                2'd2: rdata_o[BND_POS +: BND_W] = st_q.win[idx].lo;
                2'd3: rdata_o[BND_POS +: BND_W] = st_q.win[idx].hi;
                default: ;
            endcase
        end
    end

    assign cfg_o    = st_q.win;
    assign bypass_o = st_q.bypass;

    // R7
    bypass_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && is_gctl) |=> (bypass_o == $past(wdata_i[BYP_POS])));

    // R5
    ctrl_keeps_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && in_win && word == 2'd0) |=>
            (cfg_o[$past(idx)].lo == $past(cfg_o[idx].lo)) &&
            (cfg_o[$past(idx)].hi == $past(cfg_o[idx].hi)));
endmodule

// File: rtl/awd_match.sv
module awd_match
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 16
) (
    input  win_cfg_t [NUM_WIN-1:0] cfg_i,
    input  logic [PA_W-1:0]        addr_i,
    output logic [NUM_WIN-1:0]     match_o
);
    logic [BND_W-1:0] chunk;
    assign chunk = addr_i[PA_W-1:GRAN_LSB];

    for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
        logic ge_lo, le_hi;
        assign ge_lo      = (chunk >= cfg_i[n].lo);
        assign le_hi      = (chunk <= cfg_i[n].hi);
        assign match_o[n] = cfg_i[n].en && ge_lo && le_hi;
    end
endmodule

// File: rtl/awd_select.sv
module awd_select
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   valid_i,
    input  logic [NUM_WIN-1:0]     match_i,
    input  logic [NUM_WIN-1:0]     en_i,
    input  win_cfg_t [NUM_WIN-1:0] cfg_i,
    input  logic                   bypass_i,
    output logic                   valid_o,
    output logic                   hit_o,
    output logic                   miss_o,
    output logic [TGT_W-1:0]       tgt_o
);
    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             miss;
        logic [TGT_W-1:0] tgt;
    } res_t;

    res_t res_d, res_q;
    logic [TGT_W-1:0] win_tgt;

    always_comb begin
        win_tgt = '0;
        for (int n = NUM_WIN - 1; n >= 0; n--) begin
            if (match_i[n]) win_tgt = cfg_i[n].tgt;
        end
    end

    always_comb begin
        res_d.valid = valid_i;
        res_d.hit   = valid_i && (match_i != '0);
        res_d.miss  = valid_i && (match_i == '0) && !bypass_i;
        res_d.tgt   = res_d.hit ? win_tgt : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign valid_o = res_q.valid;
    assign hit_o   = res_q.hit;
    assign miss_o  = res_q.miss;
    assign tgt_o   = res_q.tgt;

    // R5
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i & ~en_i) == '0);

    // R4
    hit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(valid_i && match_i != '0));

    // R7
    miss_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_o |-> $past(valid_i && match_i == '0 && !bypass_i));

    // R7
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_o && miss_o));
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 16,
    localparam int RA_W   = $clog2(NUM_WIN) + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [RA_W-1:0]   cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              req_valid,
    input  logic [PA_W-1:0]   req_addr,
    output logic              dec_valid,
    output logic              dec_hit,
    output logic              dec_miss,
    output logic [TGT_W-1:0]  dec_target
);
    win_cfg_t [NUM_WIN-1:0] cfg;
    logic                   bypass;
    logic [NUM_WIN-1:0]     match;
    logic [NUM_WIN-1:0]     en_vec;

    for (genvar n = 0; n < NUM_WIN; n++) begin : g_en
        assign en_vec[n] = cfg[n].en;
    end

    awd_regfile #(.NUM_WIN(NUM_WIN)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr), .addr_i(cfg_addr),
        .wdata_i(cfg_wdata), .rdata_o(cfg_rdata), .cfg_o(cfg),
        .bypass_o(bypass)
    );

    awd_match #(.NUM_WIN(NUM_WIN)) i_match (
        .cfg_i(cfg), .addr_i(req_addr), .match_o(match)
    );

    awd_select #(.NUM_WIN(NUM_WIN)) i_sel (
        .clk(clk), .rst_n(rst_n), .valid_i(req_valid), .match_i(match),
        .en_i(en_vec), .cfg_i(cfg), .bypass_i(bypass),
        .valid_o(dec_valid), .hit_o(dec_hit), .miss_o(dec_miss),
        .tgt_o(dec_target)
    );

    // R8
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> !(dec_valid || dec_hit || dec_miss));
endmodule

// File: tb/test_addr_win_decoder.sv
module test_addr_win_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [8:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [43:0] req_addr = '0;
    logic        dec_valid, dec_hit, dec_miss;
    logic [3:0]  dec_target;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    addr_win_decoder i_addr_win_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .dec_valid(dec_valid), .dec_hit(dec_hit),
        .dec_miss(dec_miss), .dec_target(dec_target)
    );

    function automatic logic [43:0] pa(input logic [17:0] c, input logic [25:0] off);
        return {c, off};
    endfunction

    function automatic logic [31:0] bnd(input logic [17:0] c);
        return {4'b0, c, 10'b0};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [8:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    task automatic chk_dec(input bit hit, input logic [3:0] tgt, input bit miss,
                           input string tag);
        logic [6:0] act, exp;
        act = {dec_valid, dec_hit, dec_miss, dec_target};
        exp = {1'b1, hit, miss, tgt};
        check(act == exp, tag, act, exp);
    endtask

    task automatic probe(input logic [43:0] a, input bit hit, input logic [3:0] tgt,
                         input bit miss, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk_dec(hit, tgt, miss, tag);
    endtask

    task automatic t_reset;
        rd_chk(9'h000, 32'h0, "R1 ctrl0 reset");
        rd_chk(9'h008, 32'h0, "R1 low0 reset");
        rd_chk(9'h0FC, 32'h0, "R1 high15 reset");
        rd_chk(9'h100, 32'h0, "R1 gctl reset");
        check({dec_valid, dec_hit, dec_miss} == 3'b0, "R1 outputs idle",
              {dec_valid, dec_hit, dec_miss}, 0);
        probe(pa(18'h5, 26'h0), 1'b0, 4'h0, 1'b1, "R1 empty map misses");
    endtask

    task automatic t_fields;
        wr(9'h030, 32'hFFFF_FFFF);
        rd_chk(9'h030, 32'h0000_0F01, "R2 ctrl3 field mask");
        wr(9'h038, 32'hFFFF_FFFF);
        rd_chk(9'h038, 32'h0FFF_FC00, "R3 low3 field mask");
        wr(9'h034, 32'hFFFF_FFFF);
        rd_chk(9'h034, 32'h0, "R3 offset 4 reads zero");
        rd_chk(9'h03C, 32'h0, "R3 high3 untouched");
        wr(9'h100, 32'hFFFF_FFFF);
        rd_chk(9'h100, 32'h0000_0002, "R7 gctl field mask");
        wr(9'h100, 32'h0);
    endtask

    task automatic t_inclusive;
        wr(9'h028, bnd(18'h10));
        wr(9'h02C, bnd(18'h13));
        wr(9'h020, 32'h0000_0501);
        rd_chk(9'h020, 32'h0000_0501, "R2 ctrl2 readback");
        rd_chk(9'h02C, bnd(18'h13), "R3 high2 readback");
        probe(pa(18'h10, 26'h0), 1'b1, 4'h5, 1'b0, "R4 first byte of low granule");
        probe(pa(18'h13, 26'h3FF_FFFF), 1'b1, 4'h5, 1'b0, "R4 last byte of high granule");
        probe(pa(18'h14, 26'h0), 1'b0, 4'h0, 1'b1, "R4 just above window");
        probe(pa(18'hF, 26'h3FF_FFFF), 1'b0, 4'h0, 1'b1, "R4 just below window");
    endtask

    task automatic t_priority;
        wr(9'h078, bnd(18'h12));
        wr(9'h07C, bnd(18'h20));
        wr(9'h070, 32'h0000_0901);
        probe(pa(18'h12, 26'h100), 1'b1, 4'h5, 1'b0, "R6 window2 beats window7");
        probe(pa(18'h18, 26'h0), 1'b1, 4'h9, 1'b0, "R6 only window7 covers");
        wr(9'h018, bnd(18'h18));
        wr(9'h01C, bnd(18'h18));
        wr(9'h010, 32'h0000_0C01);
        probe(pa(18'h18, 26'h0), 1'b1, 4'hC, 1'b0, "R6 window1 beats window7");
        wr(9'h0F8, bnd(18'h3FFFF));
        wr(9'h0FC, bnd(18'h3FFFF));
        wr(9'h0F0, 32'h0000_0F01);
        probe({44{1'b1}}, 1'b1, 4'hF, 1'b0, "R4 top window at top address");
    endtask

    task automatic t_disable;
        wr(9'h010, 32'h0000_0C00);
        probe(pa(18'h18, 26'h0), 1'b1, 4'h9, 1'b0, "R5 disabled window1 skipped");
        rd_chk(9'h010, 32'h0000_0C00, "R5 target kept after disable");
        rd_chk(9'h018, bnd(18'h18), "R5 low kept after disable");
    endtask

    task automatic t_bypass;
        wr(9'h100, 32'h0000_0002);
        probe(pa(18'h100, 26'h0), 1'b0, 4'h0, 1'b0, "R7 bypass hides miss");
        wr(9'h100, 32'h0);
        probe(pa(18'h100, 26'h0), 1'b0, 4'h0, 1'b1, "R7 miss after bypass cleared");
    endtask

    task automatic t_latency;
        @(negedge clk);
        check({dec_valid, dec_hit, dec_miss} == 3'b0, "R8 idle after request",
              {dec_valid, dec_hit, dec_miss}, 0);
        @(negedge clk);
        req_valid = 1'b1; req_addr = pa(18'h10, 26'h0);
        #1;
        check(dec_valid == 1'b0, "R8 no zero-cycle result", dec_valid, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk_dec(1'b1, 4'h5, 1'b0, "R8 result after one cycle");
    endtask

    task automatic t_overlap;
        wr(9'h058, bnd(18'h30));
        wr(9'h05C, bnd(18'h30));
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 9'h050; cfg_wdata = 32'h0000_0301;
        req_valid = 1'b1; req_addr = pa(18'h30, 26'h0);
        @(negedge clk);
        cfg_wr = 1'b0; req_valid = 1'b0;
        chk_dec(1'b0, 4'h0, 1'b1, "R9 enable in same cycle not yet seen");
        probe(pa(18'h30, 26'h0), 1'b1, 4'h3, 1'b0, "R9 enable seen next request");
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 9'h050; cfg_wdata = 32'h0000_0300;
        req_valid = 1'b1; req_addr = pa(18'h30, 26'h0);
        @(negedge clk);
        cfg_wr = 1'b0; req_valid = 1'b0;
        chk_dec(1'b1, 4'h3, 1'b0, "R9 disable in same cycle not yet seen");
        probe(pa(18'h30, 26'h0), 1'b0, 4'h0, 1'b1, "R9 disable seen next request");
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 9'h100; cfg_wdata = 32'h0000_0002;
        req_valid = 1'b1; req_addr = pa(18'h200, 26'h0);
        @(negedge clk);
        cfg_wr = 1'b0; req_valid = 1'b0;
        chk_dec(1'b0, 4'h0, 1'b1, "R9 bypass set in same cycle not yet seen");
        wr(9'h100, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_fields;
        t_inclusive;
        t_priority;
        t_disable;
        t_bypass;
        t_latency;
        t_overlap;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule